// File: doc/BRIEF.md
# Dual-Set Receive DMA Ring Engine

This block takes received Ethernet frames from the MAC as a byte stream and writes them into memory. Memory is divided into slots of a fixed size. The block has two independent register sets. Each set holds a base address, a slot count and a command word. Every frame fills exactly one slot. A 16-byte header goes at the front of the slot and holds the stored length, a status byte and two error counts. The payload starts at offset 16. After the header of a frame is written, the remaining-slot count of the set in use drops by one. When a set runs out of slots it stops, and the block raises a done flag.

The host programs a set, arms it, and reads back the remaining count to see how many slots now hold frames. If the set in use is empty or paused and the other set is armed, the next frame goes to the other set. The two sets can therefore be used in ping-pong fashion: the host refills one set while the block fills the other. A shared control register can hold the channel in reset while the sets are reloaded.

Top module: `rxr_dma_ring`

## Requirements
- R1: Register map. `reg_addr[4]` selects the set. `reg_addr[3:2]` selects the register: 0 is the base address, 1 is the slot count, 2 is the command, and 3 is control on write and status on read (shared by both sets). Writing the count loads both the programmed count and the remaining count. Reading offset 1 returns the remaining count, and reading the command returns the last value written.
- R2: Command values. 0x9800 arms a set. 0x1100 pauses a set. 0x0100 clears the done flag. A paused set receives no frames until 0x9800 is written to it again.
- R3: Placement. A frame goes to the slot at base + (programmed − remaining) × 2048 of the set in use. Payload byte i is written to slot + 16 + i.
- R4: Header. The block writes only slot offsets 0, 2, 4 and 6:
  - offset 0: stored length bits 7:0
  - offset 2: status byte
  - offset 4: runt count (`in_runt` at the last byte)
  - offset 6: collision count (`in_coll` at the last byte)

  Odd offsets and offsets 8 to 15 are never written.
- R5: Status byte layout:
  - bits 3:0: stored length bits 11:8
  - bit 4: truncation (overflow)
  - bit 5: collision, from `in_err[0]`
  - bit 6: framing error, from `in_err[1]`
  - bit 7: FCS error, from `in_err[2]`

  The error bits are taken at the last byte.
- R6: A frame longer than 2032 bytes keeps its first 2032 bytes and records a length of 2032 with the overflow bit set. Nothing is written beyond its slot.
- R7: The remaining count drops by one when a frame's header is complete. When it reaches 0, the set disarms and status bit 8 (done) is set.
- R8: At the start of a frame, the set in use is kept while it is armed with slots left. Otherwise the other set is used if it is armed with slots left.
- R9: A frame that starts with no usable set is dropped: nothing is written to memory and status bit 13 (error) is set. Only a control write of 0x8800 clears it.
- R10: A control write of 0x8800 holds the channel. Frames are dropped without error, done and error are cleared, and set 0 becomes the set in use. A control write of 0x0400 releases the hold.
- R11: After reset, the status reads 0, all counts read 0, `in_ready` is high and no memory write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address (set select and register select) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Block accepts a byte |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Last byte of the frame |
| in_err | input | 3 | Frame error flags {fcs, framing, collision}, taken at the last byte |
| in_runt | input | 8 | Runt count, taken at the last byte |
| in_coll | input | 8 | Collision count, taken at the last byte |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory byte data |

## Verification
The hardest case to reach is a set change-over at the right moment. Set 0 must run out of slots on a truncated frame, and a frame must then arrive while no set is usable, before set 1 is armed. The bench reaches this by giving set 0 only three slots and sending three frames in a row: a short one, a mid-length one with error flags, and one of 2100 bytes. It then sends a frame to an empty ring before arming set 1. A final step holds the channel, reloads set 0 and re-arms both sets, which shows that the set in use after the hold is kept even though the other set is also ready.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 8;

  localparam logic [15:0] CMD_ARM   = 16'h9800;
  localparam logic [15:0] CMD_PAUSE = 16'h1100;
  localparam logic [15:0] CMD_ACK   = 16'h0100;
  localparam logic [15:0] CTL_HOLD  = 16'h8800;
  localparam logic [15:0] CTL_RUN   = 16'h0400;

  typedef enum logic [1:0] {
    REG_BASE = 2'd0,
    REG_LEN  = 2'd1,
    REG_CMD  = 2'd2,
    REG_CTL  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_DATA = 2'd1,
    W_DROP = 2'd2,
    W_HDR  = 2'd3
  } wr_state_e;

  // status byte: {fcs, framing, collision, overflow, length[11:8]}
  function automatic logic [7:0] stat_byte(logic [11:0] len, logic ovf, logic [2:0] err);
    return {err[2], err[1], err[0], ovf, len[11:8]};
  endfunction

  function automatic logic [ADDR_W-1:0] slot_addr(logic [ADDR_W-1:0] base,
                                                  logic [CNT_W-1:0] used, int sh);
    return base + (ADDR_W'(used) << sh);
  endfunction
endpackage

// File: rtl/rxr_set_regs.sv
module rxr_set_regs
  import rxr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [31:0]       wdata,
  input  logic              consume,
  output logic [ADDR_W-1:0] base,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  remain,
  output logic [15:0]       cmd,
  output logic              armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base   <= '0;
      count  <= '0;
      remain <= '0;
      cmd    <= '0;
      armed  <= 1'b0;
    end else begin
      if (consume) begin
        remain <= remain - 1'b1;
        if (remain == CNT_W'(1)) armed <= 1'b0;
      end
      if (wr_en) begin
        case (sel)
          REG_BASE: base <= wdata[ADDR_W-1:0];
          REG_LEN: begin
            count  <= wdata[CNT_W-1:0];
            remain <= wdata[CNT_W-1:0];
          end
          REG_CMD: begin
            cmd <= wdata[15:0];
            if (wdata[15:0] == CMD_ARM) armed <= 1'b1;
            else if (wdata[15:0] == CMD_PAUSE) armed <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxr_frame_writer.sv
module rxr_frame_writer
  import rxr_pkg::*;
#(
  parameter int SLOT_BYTES = 2048,
  parameter int HDR_BYTES  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        hold,
  input  logic [1:0]                  set_ready,
  input  logic [1:0][ADDR_W-1:0]      set_base,
  input  logic [1:0][CNT_W-1:0]       set_count,
  input  logic [1:0][CNT_W-1:0]       set_remain,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [7:0]                  in_data,
  input  logic                        in_last,
  input  logic [2:0]                  in_err,
  input  logic [7:0]                  in_runt,
  input  logic [7:0]                  in_coll,
  output logic                        mem_we,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic [7:0]                  mem_wdata,
  output logic [1:0]                  consume,
  output logic                        no_set
);
  localparam int SLOT_SH = $clog2(SLOT_BYTES);
  localparam int LEN_W   = SLOT_SH + 1;
  localparam logic [LEN_W-1:0] MAX_PAY = LEN_W'(SLOT_BYTES - HDR_BYTES);

  wr_state_e         state;
  logic              cur;
  logic [ADDR_W-1:0] slot_base;
  logic [LEN_W-1:0]  pay_cnt;
  logic              ovf;
  logic [2:0]        errs;
  logic [7:0]        runt, coll;
  logic [1:0]        hdr_idx;

  logic              accept, start, take, pick, pick_ok, pay_wr, hdr_wr;
  logic [ADDR_W-1:0] new_base;
  logic [CNT_W-1:0]  used;

  always_comb begin
    pick_ok = 1'b1;
    pick    = cur;
    if (set_ready[cur]) pick = cur;
    else if (set_ready[~cur]) pick = ~cur;
    else pick_ok = 1'b0;
  end

  assign in_ready = (state != W_HDR);
  assign accept   = in_valid && in_ready;
  assign start    = accept && (state == W_IDLE);
  assign take     = start && !hold && pick_ok;
  assign no_set   = start && !hold && !pick_ok;
  assign used     = set_count[pick] - set_remain[pick];
  assign new_base = slot_addr(set_base[pick], used, SLOT_SH);

  assign pay_wr = take ||
                  (accept && !hold && state == W_DATA && pay_cnt < MAX_PAY);
  assign hdr_wr = (state == W_HDR) && !hold;
  assign mem_we = pay_wr || hdr_wr;

  always_comb begin
    mem_addr  = slot_base + ADDR_W'(HDR_BYTES) + ADDR_W'(pay_cnt);
    mem_wdata = in_data;
    if (state == W_IDLE) begin
      mem_addr = new_base + ADDR_W'(HDR_BYTES);
    end else if (state == W_HDR) begin
      mem_addr = slot_base + ADDR_W'({hdr_idx, 1'b0});
      case (hdr_idx)
        2'd0:    mem_wdata = pay_cnt[7:0];
        2'd1:    mem_wdata = stat_byte(12'(pay_cnt), ovf, errs);
        2'd2:    mem_wdata = runt;
        default: mem_wdata = coll;
      endcase
    end
  end

  assign consume = (hdr_wr && hdr_idx == 2'd3) ? (cur ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= W_IDLE; cur <= 1'b0; slot_base <= '0; pay_cnt <= '0;
      ovf <= 1'b0; errs <= '0; runt <= '0; coll <= '0; hdr_idx <= '0;
    end else begin
      case (state)
        W_IDLE: begin
          if (take) begin
            cur       <= pick;
            slot_base <= new_base;
            pay_cnt   <= LEN_W'(1);
            ovf       <= 1'b0;
            hdr_idx   <= '0;
            if (in_last) begin
              errs <= in_err; runt <= in_runt; coll <= in_coll;
              state <= W_HDR;
            end else begin
              state <= W_DATA;
            end
          end else if (start && !in_last) begin
            state <= W_DROP;
          end
        end
        W_DATA: begin
          if (hold) begin
            state <= (accept && in_last) ? W_IDLE : W_DROP;
          end else if (accept) begin
            if (pay_cnt < MAX_PAY) pay_cnt <= pay_cnt + 1'b1;
            else ovf <= 1'b1;
            if (in_last) begin
              errs <= in_err; runt <= in_runt; coll <= in_coll;
              state <= W_HDR;
            end
          end
        end
        W_DROP: if (accept && in_last) state <= W_IDLE;
        default: begin
          if (hold) state <= W_IDLE;
          else begin
            hdr_idx <= hdr_idx + 1'b1;
            if (hdr_idx == 2'd3) state <= W_IDLE;
          end
        end
      endcase
      if (hold) cur <= 1'b0;
    end
  end
endmodule

// File: rtl/rxr_dma_ring.sv
module rxr_dma_ring
  import rxr_pkg::*;
#(
  parameter int SLOT_BYTES = 2048,
  parameter int HDR_BYTES  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic [2:0]  in_err,
  input  logic [7:0]  in_runt,
  input  logic [7:0]  in_coll,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [7:0]  mem_wdata
);
  logic                   set_idx;
  reg_sel_e               sel;
  logic [1:0]             set_wr, set_ready, consume, exhaust;
  logic [1:0][ADDR_W-1:0] set_base;
  logic [1:0][CNT_W-1:0]  set_count, set_remain;
  logic [1:0][15:0]       set_cmd;
  logic [1:0]             set_armed;
  logic                   hold_q, done_q, err_q, no_set;
  logic                   ctl_wr, ack_wr;

  assign set_idx = reg_addr[4];
  assign sel     = reg_sel_e'(reg_addr[3:2]);
  assign ctl_wr  = reg_we && (sel == REG_CTL);
  assign ack_wr  = reg_we && (sel == REG_CMD) && (reg_wdata[15:0] == CMD_ACK);

  for (genvar g = 0; g < 2; g++) begin : g_set
    assign set_wr[g] = reg_we && (set_idx == g[0]) && (sel != REG_CTL);
    rxr_set_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(set_wr[g]), .sel(sel), .wdata(reg_wdata),
      .consume(consume[g]), .base(set_base[g]), .count(set_count[g]),
      .remain(set_remain[g]), .cmd(set_cmd[g]), .armed(set_armed[g])
    );
    assign set_ready[g] = set_armed[g] && (set_remain[g] != '0);
    assign exhaust[g]   = consume[g] && (set_remain[g] == CNT_W'(1));
  end

  rxr_frame_writer #(.SLOT_BYTES(SLOT_BYTES), .HDR_BYTES(HDR_BYTES)) u_wr (
    .clk(clk), .rst_n(rst_n), .hold(hold_q), .set_ready(set_ready),
    .set_base(set_base), .set_count(set_count), .set_remain(set_remain),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .in_err(in_err), .in_runt(in_runt), .in_coll(in_coll),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .consume(consume), .no_set(no_set)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      if (ctl_wr && reg_wdata[15:0] == CTL_HOLD) begin
        hold_q <= 1'b1; done_q <= 1'b0; err_q <= 1'b0;
      end else if (ctl_wr && reg_wdata[15:0] == CTL_RUN) begin
        hold_q <= 1'b0;
      end
      if (ack_wr) done_q <= 1'b0;
      if (|exhaust) done_q <= 1'b1;
      if (no_set) err_q <= 1'b1;
    end
  end

  always_comb begin
    case (sel)
      REG_BASE: reg_rdata = set_base[set_idx];
      REG_LEN:  reg_rdata = 32'(set_remain[set_idx]);
      REG_CMD:  reg_rdata = 32'(set_cmd[set_idx]);
      default:  reg_rdata = (32'(err_q) << 13) | (32'(done_q) << 8);
    endcase
  end
endmodule

// File: rtl/rxr_dma_ring_chk.sv
module rxr_dma_ring_chk
  import rxr_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_we,
  input logic [2:0]            reg_sel,
  input logic [15:0]           reg_wlo,
  input logic                  mem_we,
  input logic                  hold_q,
  input logic                  done_q,
  input logic                  err_q,
  input logic                  no_set,
  input logic [1:0]            exhaust,
  input logic [1:0]            consume,
  input logic [1:0][CNT_W-1:0] remain
);
  logic len_wr0, len_wr1, hold_wr;
  assign len_wr0 = reg_we && reg_sel == 3'b001;
  assign len_wr1 = reg_we && reg_sel == 3'b101;
  assign hold_wr = reg_we && reg_sel[1:0] == 2'b11 && reg_wlo == CTL_HOLD;

  AST_HOLD_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> !mem_we) else $error("hold write"); // R10
  AST_ONE_CONSUMER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(consume)) else $error("two consumers"); // R7
  AST_DONE_AFTER_EXHAUST: assert property (@(posedge clk) disable iff (!rst_n)
    (|exhaust) |=> done_q) else $error("done missing"); // R7
  AST_REMAIN_STEP0: assert property (@(posedge clk) disable iff (!rst_n)
    (consume[0] && !len_wr0) |=> remain[0] == $past(remain[0]) - 1'b1) else $error("step0"); // R7
  AST_REMAIN_STEP1: assert property (@(posedge clk) disable iff (!rst_n)
    (consume[1] && !len_wr1) |=> remain[1] == $past(remain[1]) - 1'b1) else $error("step1"); // R7
  AST_NO_SET_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    no_set |-> !mem_we) else $error("write on drop"); // R9
  AST_ERR_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    no_set |=> err_q) else $error("err missing"); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !hold_wr) |=> err_q) else $error("err lost"); // R9
endmodule

bind rxr_dma_ring rxr_dma_ring_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_addr[4:2]),
  .reg_wlo(reg_wdata[15:0]), .mem_we(mem_we), .hold_q(hold_q), .done_q(done_q),
  .err_q(err_q), .no_set(no_set), .exhaust(exhaust), .consume(consume),
  .remain(set_remain)
);

// File: tb/sim_rxr_dma_ring.sv
`timescale 1ns/1ps
module sim_rxr_dma_ring;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic in_valid = 1'b0, in_ready, in_last = 1'b0;
  logic [7:0] in_data = '0, in_runt = '0, in_coll = '0;
  logic [2:0] in_err = '0;
  logic mem_we;
  logic [31:0] mem_addr;
  logic [7:0] mem_wdata;

  int n_chk = 0, n_fail = 0, wr_cnt = 0;
  logic [7:0] mem [int unsigned];

  localparam logic [31:0] B0 = 32'h0010_0000, B1 = 32'h0040_0000, B2 = 32'h0080_0000;

  always #10 clk = ~clk;

  rxr_dma_ring u0 (.*);

  always @(posedge clk) if (mem_we) begin mem[mem_addr] = mem_wdata; wr_cnt++; end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [4:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_reg(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] mb(logic [31:0] a);
    return mem.exists(a) ? 32'(mem[a]) : 32'hDEAD;
  endfunction

  task automatic send(int n, logic [2:0] e, logic [7:0] rc, logic [7:0] cc, logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_data = 8'(seed + i); in_last = (i == n - 1);
      in_err = e; in_runt = rc; in_coll = cc;
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // header and payload of one slot, expectations from R3/R4/R5
  task automatic chk_slot(string tag, logic [31:0] s, int stored, logic ovf,
                          logic [2:0] e, logic [7:0] rc, logic [7:0] cc, logic [7:0] seed);
    logic [7:0] st;
    st = 8'((stored >> 8) & 15) | (8'(ovf) << 4) | (8'(e) << 5);
    chk({tag, " R4 len lo"}, mb(s), 32'(stored & 255));
    chk({tag, " R5 status"}, mb(s + 2), 32'(st));
    chk({tag, " R4 runt"}, mb(s + 4), 32'(rc));
    chk({tag, " R4 coll"}, mb(s + 6), 32'(cc));
    chk({tag, " R4 odd pad"}, 32'(mem.exists(s + 1)), 0);
    chk({tag, " R4 word pad"}, 32'(mem.exists(s + 8)), 0);
    chk({tag, " R3 first"}, mb(s + 16), 32'(seed));
    chk({tag, " R3 last"}, mb(s + 16 + stored - 1), 32'(8'(seed + stored - 1)));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd_reg(5'h0C, d); chk("R11 status", d, 0);
    rd_reg(5'h04, d); chk("R11 remain0", d, 0);
    chk("R11 ready", 32'(in_ready), 1);
    chk("R11 no writes", wr_cnt, 0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    wr_reg(5'h00, B0); wr_reg(5'h04, 3); wr_reg(5'h08, 32'h9800);
    rd_reg(5'h00, d); chk("R1 base readback", d, B0);
    rd_reg(5'h04, d); chk("R1 remain loaded", d, 3);
    send(60, 3'b000, 8'd3, 8'd1, 8'h10);
    chk_slot("basic", B0, 60, 1'b0, 3'b000, 8'd3, 8'd1, 8'h10);
    chk("R3 past end", 32'(mem.exists(B0 + 16 + 60)), 0);
    rd_reg(5'h04, d); chk("R7 remain 2", d, 2);
  endtask

  task automatic t_flags();
    logic [31:0] d;
    send(300, 3'b101, 8'd0, 8'd2, 8'h80);
    chk_slot("flags", B0 + 2048, 300, 1'b0, 3'b101, 8'd0, 8'd2, 8'h80);
    chk("R5 status literal", mb(B0 + 2048 + 2), 32'hA1);
    rd_reg(5'h04, d); chk("R7 remain 1", d, 1);
  endtask

  task automatic t_trunc();
    logic [31:0] d;
    send(2100, 3'b000, 8'd0, 8'd0, 8'h00);
    chk_slot("trunc R6", B0 + 4096, 2032, 1'b1, 3'b000, 8'd0, 8'd0, 8'h00);
    chk("R6 status literal", mb(B0 + 4096 + 2), 32'h17);
    chk("R6 nothing past slot", 32'(mem.exists(B0 + 6144)), 0);
    rd_reg(5'h04, d); chk("R7 remain 0", d, 0);
    rd_reg(5'h0C, d); chk("R7 done", d, 32'h100);
    rd_reg(5'h08, d); chk("R1 cmd readback", d, 32'h9800);
  endtask

  task automatic t_none();
    logic [31:0] d;
    int w0;
    w0 = wr_cnt;
    send(20, 3'b000, 8'd0, 8'd0, 8'h44);
    chk("R9 no write", wr_cnt, w0);
    rd_reg(5'h0C, d); chk("R9 error bit", d, 32'h2100);
  endtask

  task automatic t_switch();
    logic [31:0] d;
    wr_reg(5'h10, B1); wr_reg(5'h14, 2); wr_reg(5'h18, 32'h9800);
    wr_reg(5'h08, 32'h0100);
    rd_reg(5'h0C, d); chk("R2 ack clears done", d, 32'h2000);
    send(40, 3'b010, 8'd5, 8'd0, 8'h33);
    chk_slot("switch R8", B1, 40, 1'b0, 3'b010, 8'd5, 8'd0, 8'h33);
    rd_reg(5'h14, d); chk("R8 remain1", d, 1);
  endtask

  task automatic t_pause();
    logic [31:0] d;
    int w0;
    wr_reg(5'h18, 32'h1100);
    w0 = wr_cnt;
    send(10, 3'b000, 8'd0, 8'd0, 8'h01);
    chk("R2 paused no write", wr_cnt, w0);
    rd_reg(5'h14, d); chk("R2 paused remain", d, 1);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    int w0;
    wr_reg(5'h0C, 32'h8800);
    rd_reg(5'h0C, d); chk("R10 hold clears status", d, 0);
    wr_reg(5'h18, 32'h9800);
    w0 = wr_cnt;
    send(10, 3'b000, 8'd0, 8'd0, 8'h02);
    chk("R10 held no write", wr_cnt, w0);
    rd_reg(5'h0C, d); chk("R10 held no error", d, 0);
    wr_reg(5'h00, B2); wr_reg(5'h04, 4); wr_reg(5'h08, 32'h9800);
    wr_reg(5'h0C, 32'h0400);
    send(16, 3'b000, 8'd0, 8'd0, 8'h55);
    chk_slot("hold R10", B2, 16, 1'b0, 3'b000, 8'd0, 8'd0, 8'h55);
    rd_reg(5'h04, d); chk("R8 stays set0", d, 3);
    rd_reg(5'h14, d); chk("R8 set1 untouched", d, 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_flags();
    t_trunc();
    t_none();
    t_switch();
    t_pause();
    t_hold();
    finish_run();
  end
endmodule